// File: doc/BRIEF.md
# Exception Vector Catch Unit

This block watches the instruction stream at commit and raises a debug event request when a committed instruction sits at the address of an exception vector whose catch has been enabled by software. The match is made on the committed address, not on exception entry. A plain branch into a vector location therefore triggers it in the same way as a real exception.

An eight-bit enable register is written and read through a simple synchronous port. Each implemented bit arms one vector slot. The slot addresses come from a vector base, which is either all zeros or 0xFFFF0000 depending on a high-vectors input, plus four times the slot index. The IRQ slot can instead follow a handler address supplied by an external interrupt controller. While monitor debug mode is active, no event is produced, whatever the enables say.

Top module: `vcatch_unit`

## Requirements
- R1: After reset, read data is 0x00000000 and `catch_o` is low.
- R2: Enable bits 0,1,2,3,4,6,7 are written from `reg_wdata_i` and read back on `reg_rdata_o`. Bit 5 and bits 31:8 always read as zero, and writing them has no effect.
- R3: With `high_vec_i` low, a commit at address 4*k arms slot k for k in {0,1,2,3,4,6,7}. The slots are 0 reset, 1 undefined, 2 supervisor call, 3 prefetch abort, 4 data abort, 6 IRQ and 7 FIQ. Such a commit raises `catch_o` when enable bit k is set.
- R4: With `high_vec_i` high, the slot addresses are 0xFFFF0000 + 4*k, and the low-base addresses no longer match.
- R5: With `vic_en_i` high, slot 6 compares against `vic_irq_addr_i` whatever `high_vec_i` is. Its fixed vector address then no longer matches.
- R6: While `mon_mode_i` is high, no commit raises `catch_o`.
- R7: `catch_o` is a one-cycle pulse in the cycle after a matching commit with `commit_valid_i` high. A matching address without `commit_valid_i` produces nothing.
- R8: A commit at a vector whose enable bit is clear, or at offset 0x14 of the reserved slot 5, raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Enable register write strobe |
| reg_wdata_i | input | 32 | Enable register write data |
| reg_rdata_o | output | 32 | Enable register read data (combinational) |
| commit_valid_i | input | 1 | An instruction commits this cycle |
| commit_addr_i | input | 32 | Address of the committing instruction |
| high_vec_i | input | 1 | Selects vector base 0xFFFF0000 |
| vic_en_i | input | 1 | IRQ slot follows the controller-supplied address |
| vic_irq_addr_i | input | 32 | Last IRQ handler address from the interrupt controller |
| mon_mode_i | input | 1 | Monitor debug mode selected and enabled |
| catch_o | output | 1 | Vector catch debug event pulse |

## Verification
A stuck or wrongly decoded enable bit shows up immediately on `reg_rdata_o`, in the same cycle as the write edge. A bad slot address or base selection shows up one cycle after the offending commit as a missing or extra `catch_o` pulse. A wrong suppression or pulse-width fault shows up as `catch_o` being high in a cycle that was not preceded by a qualifying commit. Every fault class is therefore visible within one clock of its stimulus.

// File: rtl/vcatch_pkg.sv
package vcatch_pkg;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned SLOTS     = 8;
  localparam int unsigned IRQ_SLOT  = 6;
  localparam logic [SLOTS-1:0] IMPL_MASK = 8'b1101_1111;
  localparam logic [ADDR_W-1:0] LOW_BASE  = 32'h0000_0000;
  localparam logic [ADDR_W-1:0] HIGH_BASE = 32'hFFFF_0000;

  typedef logic [SLOTS-1:0][ADDR_W-1:0] vec_tbl_t;
endpackage

// File: rtl/vcatch_enable_reg.sv
module vcatch_enable_reg
  import vcatch_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic [SLOTS-1:0] en_o
);
  logic [SLOTS-1:0] en_q;
  logic             unused_hi;

  assign unused_hi = ^wdata_i[DW-1:SLOTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (we_i) en_q <= wdata_i[SLOTS-1:0] & IMPL_MASK;
  end

  assign en_o    = en_q;
  assign rdata_o = {{(DW-SLOTS){1'b0}}, en_q};
endmodule

// File: rtl/vcatch_addr_gen.sv
module vcatch_addr_gen
  import vcatch_pkg::*;
(
  input  logic              high_vec_i,
  input  logic              vic_en_i,
  input  logic [ADDR_W-1:0] vic_irq_addr_i,
  output vec_tbl_t          vec_addr_o
);
  logic [ADDR_W-1:0] base;
  assign base = high_vec_i ? HIGH_BASE : LOW_BASE;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    localparam logic [ADDR_W-1:0] OFF = ADDR_W'(k) << 2;
    if (k == IRQ_SLOT) begin : g_irq
      // controller address overrides base regardless of high vectors
      assign vec_addr_o[k] = vic_en_i ? vic_irq_addr_i : (base | OFF);
    end else begin : g_fixed
      assign vec_addr_o[k] = base | OFF;
    end
  end
endmodule

// File: rtl/vcatch_match.sv
module vcatch_match
  import vcatch_pkg::*;
(
  input  logic [SLOTS-1:0]  en_i,
  input  vec_tbl_t          vec_addr_i,
  input  logic [ADDR_W-1:0] commit_addr_i,
  output logic              hit_o
);
  logic [SLOTS-1:0] slot_hit;

  for (genvar k = 0; k < SLOTS; k++) begin : g_cmp
    if (IMPL_MASK[k]) begin : g_live
      assign slot_hit[k] = en_i[k] && (commit_addr_i == vec_addr_i[k]);
    end else begin : g_dead
      logic unused_slot;
      assign unused_slot = en_i[k] ^ (^vec_addr_i[k]);
      assign slot_hit[k] = 1'b0;
    end
  end

  assign hit_o = |slot_hit;
endmodule

// File: rtl/vcatch_unit.sv
module vcatch_unit
  import vcatch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              commit_valid_i,
  input  logic [31:0]       commit_addr_i,
  input  logic              high_vec_i,
  input  logic              vic_en_i,
  input  logic [31:0]       vic_irq_addr_i,
  input  logic              mon_mode_i,
  output logic              catch_o
);
  logic [SLOTS-1:0] en;
  vec_tbl_t         vec_addr;
  logic             hit;
  logic             catch_q;

  vcatch_enable_reg #(.DW(32)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .en_o    (en)
  );

  vcatch_addr_gen u_gen (
    .high_vec_i     (high_vec_i),
    .vic_en_i       (vic_en_i),
    .vic_irq_addr_i (vic_irq_addr_i),
    .vec_addr_o     (vec_addr)
  );

  vcatch_match u_match (
    .en_i          (en),
    .vec_addr_i    (vec_addr),
    .commit_addr_i (commit_addr_i),
    .hit_o         (hit)
  );

  // monitor mode masks all enables
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) catch_q <= 1'b0;
    else         catch_q <= commit_valid_i && hit && !mon_mode_i;
  end

  assign catch_o = catch_q;
endmodule

// File: rtl/vcatch_unit_chk.sv
module vcatch_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        commit_valid_i,
  input logic        mon_mode_i,
  input logic [31:0] reg_rdata_o,
  input logic        catch_o
);
  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[31:8] == '0 && reg_rdata_o[5] == 1'b0);

  assert_mon_block_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    catch_o |-> !$past(mon_mode_i));

  assert_needs_commit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    catch_o |-> $past(commit_valid_i));

  assert_needs_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    catch_o |-> $past(reg_rdata_o[7:0]) != 8'h00);
endmodule

bind vcatch_unit vcatch_unit_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .commit_valid_i (commit_valid_i),
  .mon_mode_i     (mon_mode_i),
  .reg_rdata_o    (reg_rdata_o),
  .catch_o        (catch_o)
);

// File: tb/vcatch_unit_tb.sv
module vcatch_unit_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        commit_valid_i = 1'b0;
  logic [31:0] commit_addr_i = '0;
  logic        high_vec_i = 1'b0;
  logic        vic_en_i = 1'b0;
  logic [31:0] vic_irq_addr_i = '0;
  logic        mon_mode_i = 1'b0;
  logic        catch_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  vcatch_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .commit_valid_i(commit_valid_i),
    .commit_addr_i(commit_addr_i), .high_vec_i(high_vec_i), .vic_en_i(vic_en_i),
    .vic_irq_addr_i(vic_irq_addr_i), .mon_mode_i(mon_mode_i), .catch_o(catch_o)
  );

  typedef struct packed {
    logic [7:0]  en;
    logic        hv;
    logic        vic;
    logic        mon;
    logic [31:0] addr;
    logic [31:0] vaddr;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{8'h01, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'h0, 1'b1, 4'd3}, // R3 reset slot
    '{8'h02, 1'b0, 1'b0, 1'b0, 32'h0000_0004, 32'h0, 1'b1, 4'd3}, // R3 undefined
    '{8'h04, 1'b0, 1'b0, 1'b0, 32'h0000_0008, 32'h0, 1'b1, 4'd3}, // R3 svc
    '{8'h04, 1'b0, 1'b0, 1'b0, 32'h0000_000C, 32'h0, 1'b0, 4'd8}, // R8 other slot disabled
    '{8'h08, 1'b1, 1'b0, 1'b0, 32'hFFFF_000C, 32'h0, 1'b1, 4'd4}, // R4 high base
    '{8'h08, 1'b1, 1'b0, 1'b0, 32'h0000_000C, 32'h0, 1'b0, 4'd4}, // R4 low addr ignored
    '{8'h10, 1'b0, 1'b0, 1'b0, 32'h0000_0010, 32'h0, 1'b1, 4'd3}, // R3 data abort
    '{8'h40, 1'b0, 1'b0, 1'b0, 32'h0000_0018, 32'h0, 1'b1, 4'd3}, // R3 irq fixed
    '{8'h40, 1'b0, 1'b1, 1'b0, 32'h1234_5678, 32'h1234_5678, 1'b1, 4'd5}, // R5 vic addr
    '{8'h40, 1'b1, 1'b1, 1'b0, 32'hFFFF_0018, 32'h1234_5678, 1'b0, 4'd5}, // R5 fixed addr off
    '{8'h80, 1'b1, 1'b0, 1'b0, 32'hFFFF_001C, 32'h0, 1'b1, 4'd4}, // R4 fiq high
    '{8'hFF, 1'b0, 1'b0, 1'b0, 32'h0000_0014, 32'h0, 1'b0, 4'd8}, // R8 reserved offset
    '{8'hFF, 1'b0, 1'b0, 1'b1, 32'h0000_0000, 32'h0, 1'b0, 4'd6}, // R6 monitor
    '{8'h00, 1'b0, 1'b0, 1'b0, 32'h0000_001C, 32'h0, 1'b0, 4'd8}  // R8 none enabled
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); reg_we_i = 1'b1; reg_wdata_i = d;
    @(negedge clk); reg_we_i = 1'b0;
  endtask

  task automatic commit(input logic [31:0] a, input logic v);
    @(negedge clk); commit_valid_i = v; commit_addr_i = a;
    @(posedge clk); #1;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", reg_rdata_o, 32'h0);
    check("R1", {31'b0, catch_o}, 32'h0);
    rst_ni = 1'b1;

    // R2 readback masking
    wr(32'hFFFF_FFFF);
    check("R2", reg_rdata_o, 32'h0000_00DF);
    wr(32'hFFFF_FF20);
    check("R2", reg_rdata_o, 32'h0000_0000);

    for (int i = 0; i < NV; i++) begin
      wr({24'h0, VT[i].en});
      high_vec_i = VT[i].hv; vic_en_i = VT[i].vic;
      mon_mode_i = VT[i].mon; vic_irq_addr_i = VT[i].vaddr;
      commit(VT[i].addr, 1'b1);
      check($sformatf("R%0d vec%0d", VT[i].req, i), {31'b0, catch_o}, {31'b0, VT[i].exp});
      commit(32'h0000_1000, 1'b0);
      check("R7 pulse ends", {31'b0, catch_o}, 32'h0);
    end
    high_vec_i = 0; vic_en_i = 0; mon_mode_i = 0;

    // R7: matching address but no valid strobe
    wr(32'h0000_0001);
    commit(32'h0, 1'b0);
    check("R7 no strobe", {31'b0, catch_o}, 32'h0);
    // R7: back-to-back commits give back-to-back pulses, then drops
    commit(32'h0, 1'b1);
    check("R7 first", {31'b0, catch_o}, 32'h1);
    commit(32'h0, 1'b1);
    check("R7 second", {31'b0, catch_o}, 32'h1);
    commit(32'h0, 1'b0);
    check("R7 drop", {31'b0, catch_o}, 32'h0);

    // R1: reset mid-run clears register and event
    wr(32'h0000_00DF);
    @(negedge clk); commit_valid_i = 1'b1; commit_addr_i = 32'h0;
    @(negedge clk); rst_ni = 1'b0; commit_valid_i = 1'b0; #1;
    check("R1 rst rdata", reg_rdata_o, 32'h0);
    check("R1 rst catch", {31'b0, catch_o}, 32'h0);
    @(negedge clk); rst_ni = 1'b1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule